// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to sixteen interrupt sources and raises one request line to a processor. Each source has a 3-bit priority and a trigger mode, either level or rising edge. The controller compares the best unmasked pending source with the level currently in service. It asserts the request only when that source is strictly more urgent, so a handler can be preempted only by a higher priority.

Software drives the block through a small register bus. Reading the vector register acknowledges the winning source:
- the level in service rises to the winner's priority;
- the level it replaces is saved on an internal stack;
- an edge source has its pending flag cleared.

Writing the end-of-service register restores the saved level. Other registers set and clear mask bits, report the mask, force or drop pending flags on edge sources, and hold each source's configuration. A debug input makes vector reads free of side effects, so a monitor can inspect the controller without disturbing it.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the request line is low, every mask bit reads 0, every source is a level source of priority 0, and no level is in service.
- R2: Mask bits are changed by writing 1s: writing address 2 sets the marked bits, and writing address 3 clears them. Reading address 4 returns the mask in bits [NUM_SRC-1:0].
- R3: Among unmasked pending sources, the one with the highest priority wins. Equal priorities go to the lower index. The vector reported is the index plus 1, in the low bits of a read of address 0.
- R4: The request line rises one cycle after an unmasked pending source has a priority strictly above the level in service. Masked sources, and sources at or below that level, never raise it.
- R5: A vector read at address 0 while a winner exists does the following: the level in service becomes the winner's priority, the previous level is pushed on the stack, and the request line is low in the following cycle.
- R6: An acknowledge clears the pending flag of an edge-triggered winner. A level source stays pending while its input is high.
- R7: If a more urgent source becomes pending after the request has risen but before the read, the read returns the new vector and takes its priority.
- R8: A write to address 1 restores the level in service from the top of the stack. With the stack empty it changes nothing. The stack holds 8 entries, so all 8 priorities can nest.
- R9: Writing 1s to address 5 forces pending flags on, and writing to address 6 clears them. Both affect edge sources only and have no effect on level sources.
- R10: A vector read with no winner above the level in service returns 0 and changes neither the level nor the stack.
- R11: With the debug input high, a vector read returns the same value as a normal read but does not change the level, the stack or any pending flag.
- R12: The configuration of source n sits at address 16+n: bits [2:0] hold the priority and bit 3 selects edge mode. Edge sources set their pending flag on a rising input edge seen through a two-flop synchronizer. Level sources follow the synchronized input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Asynchronous interrupt inputs |
| dbg_i | input | 1 | Debug mode, vector reads without side effects |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe, zero otherwise |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the controller with its defaults: eight sources, eight priority levels and an eight-deep stack. With one source per priority, nesting can be driven all the way down to a full stack, and the end-of-service writes can then unwind it through to an empty stack. Eight sources also allow a priority tie between two edge sources and a level source mixed among edge sources on the same register bus.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int BUS_AW = 5;
  localparam logic [BUS_AW-1:0] A_VEC   = 5'd0;
  localparam logic [BUS_AW-1:0] A_EOS   = 5'd1;
  localparam logic [BUS_AW-1:0] A_MSET  = 5'd2;
  localparam logic [BUS_AW-1:0] A_MCLR  = 5'd3;
  localparam logic [BUS_AW-1:0] A_MSTAT = 5'd4;
  localparam logic [BUS_AW-1:0] A_PSET  = 5'd5;
  localparam logic [BUS_AW-1:0] A_PCLR  = 5'd6;
endpackage

// File: rtl/nic_src_front.sv
module nic_src_front #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] edge_mode_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic rise;
    assign rise = s2_q[i] & ~prev_q[i];

    always_ff @(posedge clk) begin
      if (rst)
        pend_o[i] <= 1'b0;
      else if (edge_mode_i[i])
        pend_o[i] <= (pend_o[i] & ~(clr_i[i] | ack_clr_i[i])) | set_i[i] | rise;
      else
        pend_o[i] <= s2_q[i];
    end

    // R9: level sources ignore software set/clear and follow the synchronizer
    a_r9_level_follows: assert property (@(posedge clk) disable iff (rst)
      !$past(edge_mode_i[i]) && !$past(rst) |-> pend_o[i] == $past(s2_q[i]));
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        mask_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [PRIO_W-1:0]         win_prio_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && mask_i[i] &&
          (!win_valid_o || prio_i[i*PRIO_W +: PRIO_W] >= win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R3: the winner is always an enabled, pending source
  a_r3_winner_enabled: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> pend_i[win_idx_o] && mask_i[win_idx_o]);
  // R4: no winner while every enabled source is idle
  a_r4_masked_ignored: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & mask_i) == '0) |-> !win_valid_o);
endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4,
  localparam int SP_W = $clog2(DEPTH + 1),
  localparam int IX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] din_i,
  output logic [LVL_W-1:0] top_o,
  output logic             empty_o
);
  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [IX_W-1:0]  top_ix;

  assign top_ix  = IX_W'(sp_q - 1'b1);
  assign top_o   = mem_q[top_ix];
  assign empty_o = (sp_q == '0);

  always_ff @(posedge clk) begin
    if (push_i) mem_q[IX_W'(sp_q)] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sp_q <= '0;
    else if (push_i && !pop_i)
      sp_q <= sp_q + 1'b1;
    else if (pop_i && !push_i)
      sp_q <= sp_q - 1'b1;
  end

  // R8: nesting never exceeds the stack depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> sp_q < SP_W'(DEPTH));
  // R8: a pop on an empty stack never happens
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 8,
  parameter int DATA_W      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               dbg_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [4:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int VEC_W = $clog2(NUM_SRC + 1);
  localparam int LVL_W = PRIO_W + 1;  // 0 = idle, p+1 = priority p in service

  logic [NUM_SRC-1:0]        mask_q, edge_q, pend, ack_clr;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [LVL_W-1:0]          cur_q, win_lvl, stk_top;
  logic                      win_valid, irq_cond, rd_vec, ack, eos, pop, stk_empty;
  logic [IDX_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;
  logic [VEC_W-1:0]          vec;
  logic                      cfg_hit;
  logic [3:0]                cfg_ix;

  assign cfg_ix   = bus_addr_i[3:0];
  assign cfg_hit  = bus_addr_i[4] && (int'(cfg_ix) < NUM_SRC);

  nic_src_front #(.NUM_SRC(NUM_SRC)) u_front (
    .clk(clk), .rst(rst), .src_i(src_i), .edge_mode_i(edge_q),
    .set_i((bus_wr_i && bus_addr_i == A_PSET) ? bus_wdata_i[NUM_SRC-1:0] : '0),
    .clr_i((bus_wr_i && bus_addr_i == A_PCLR) ? bus_wdata_i[NUM_SRC-1:0] : '0),
    .ack_clr_i(ack_clr), .pend_o(pend));

  nic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask_q), .prio_i(prio_q),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_prio_o(win_prio));

  assign win_lvl  = {1'b0, win_prio} + 1'b1;
  assign irq_cond = win_valid && (win_lvl > cur_q);
  assign rd_vec   = bus_rd_i && (bus_addr_i == A_VEC);
  assign ack      = rd_vec && irq_cond && !dbg_i;
  assign eos      = bus_wr_i && (bus_addr_i == A_EOS);
  assign pop      = eos && !stk_empty && !ack;
  assign vec      = irq_cond ? VEC_W'(win_idx) + 1'b1 : '0;
  assign ack_clr  = ack ? (edge_q & (NUM_SRC'(1) << win_idx)) : '0;

  nic_prio_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stack (
    .clk(clk), .rst(rst), .push_i(ack), .pop_i(pop), .din_i(cur_q),
    .top_o(stk_top), .empty_o(stk_empty));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      irq_o  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ack)      cur_q <= win_lvl;
      else if (pop) cur_q <= stk_top;
      irq_o <= irq_cond && !ack;
      if (bus_wr_i && bus_addr_i == A_MSET) mask_q <= mask_q | bus_wdata_i[NUM_SRC-1:0];
      if (bus_wr_i && bus_addr_i == A_MCLR) mask_q <= mask_q & ~bus_wdata_i[NUM_SRC-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q[i*PRIO_W +: PRIO_W] <= '0;
        edge_q[i]                  <= 1'b0;
      end else if (bus_wr_i && cfg_hit && int'(cfg_ix) == i) begin
        prio_q[i*PRIO_W +: PRIO_W] <= bus_wdata_i[PRIO_W-1:0];
        edge_q[i]                  <= bus_wdata_i[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd_i)
      bus_rdata_o <= '0;
    else if (bus_addr_i == A_VEC)
      bus_rdata_o <= DATA_W'(vec);
    else if (bus_addr_i == A_MSTAT)
      bus_rdata_o <= DATA_W'(mask_q);
    else if (cfg_hit)
      bus_rdata_o <= DATA_W'({edge_q[cfg_ix[IDX_W-1:0]], prio_q[cfg_ix[IDX_W-1:0]*PRIO_W +: PRIO_W]});
    else
      bus_rdata_o <= '0;
  end

  // R5: an acknowledge drops the request in the next cycle
  a_r5_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_o);
  // R5: an acknowledge raises the level to the winner's priority
  a_r5_level_raised: assert property (@(posedge clk) disable iff (rst)
    ack |=> cur_q > $past(cur_q));
  // R10: a read with no winner leaves the level unchanged
  a_r10_fake_keeps_level: assert property (@(posedge clk) disable iff (rst)
    rd_vec && !irq_cond |=> $stable(cur_q));
  // R11: debug reads leave the level unchanged
  a_r11_debug_no_effect: assert property (@(posedge clk) disable iff (rst)
    rd_vec && dbg_i |=> $stable(cur_q));
  // R4: the request is only raised for a winner above the level
  a_r4_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_cond));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src = '0;
  logic        dbg = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .src_i(src), .dbg_i(dbg), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  // ---------------- behavioural reference model ----------------
  int m_s1[N], m_s2[N], m_prev[N], m_pend[N], m_mask[N], m_prio[N], m_edge[N];
  int m_cur;          // -1 = idle
  int m_stk[$];
  bit m_irq;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
        m_mask[i] = 0; m_prio[i] = 0; m_edge[i] = 0;
      end
      m_cur = -1; m_stk.delete(); m_irq = 0; m_rdata = 0;
    end else begin
      int bi, bp, wi;
      bit found, cond, ack;
      found = 0; bi = 0; bp = 0;
      for (int i = 0; i < N; i++)
        if (m_pend[i] != 0 && m_mask[i] != 0 && (!found || m_prio[i] > bp)) begin
          found = 1; bi = i; bp = m_prio[i];
        end
      cond = found && (bp > m_cur);
      ack  = rd && addr == 5'd0 && cond && !dbg;
      m_rdata = 0;
      if (rd) begin
        if (addr == 5'd0) m_rdata = cond ? bi + 1 : 0;
        else if (addr == 5'd4) for (int i = 0; i < N; i++) m_rdata[i] = m_mask[i][0];
        else if (addr >= 16 && addr < 16 + N) m_rdata = m_prio[addr-16] + 8 * m_edge[addr-16];
      end
      m_irq = cond && !ack;
      for (int i = 0; i < N; i++) begin
        if (m_edge[i] != 0) begin
          bit p;
          p = m_pend[i] != 0;
          if (wr && addr == 5'd6 && wdata[i]) p = 0;
          if (ack && bi == i) p = 0;
          if (wr && addr == 5'd5 && wdata[i]) p = 1;
          if (m_s2[i] != 0 && m_prev[i] == 0) p = 1;
          m_pend[i] = p;
        end else m_pend[i] = m_s2[i];
      end
      if (ack) begin m_stk.push_back(m_cur); m_cur = bp; end
      else if (wr && addr == 5'd1 && m_stk.size() > 0) m_cur = m_stk.pop_back();
      if (wr && addr == 5'd2) for (int i = 0; i < N; i++) if (wdata[i]) m_mask[i] = 1;
      if (wr && addr == 5'd3) for (int i = 0; i < N; i++) if (wdata[i]) m_mask[i] = 0;
      if (wr && addr >= 16 && addr < 16 + N) begin
        wi = addr - 16; m_prio[wi] = wdata[2:0]; m_edge[wi] = wdata[3];
      end
      for (int i = 0; i < N; i++) begin
        m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = src[i];
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq !== m_irq || rdata !== m_rdata) begin
        failures++;
        $display("FAIL %s model compare: irq=%0b rdata=%0h expected irq=%0b rdata=%0h",
                 tag, irq, rdata, m_irq, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic br(input logic [4:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3); rst = 1'b0; idle(1);
    tag = "R1"; chk("R1 irq after reset", {31'b0, irq}, 0);
    br(5'd4, v); chk("R1 mask after reset", v, 0);
    br(5'd17, v); chk("R1 config after reset", v, 0);

    tag = "R2";
    bw(5'd2, 32'hFF); bw(5'd3, 32'h0C);
    br(5'd4, v); chk("R2 mask status", v, 32'hF3);

    tag = "R12";
    bw(5'd16, 32'h2);        // src0 level prio2
    bw(5'd17, 32'hD);        // src1 edge prio5
    bw(5'd18, 32'hD);        // src2 edge prio5
    bw(5'd19, 32'h9);        // src3 edge prio1
    br(5'd17, v); chk("R12 config readback", v, 32'hD);
    bw(5'd2, 32'h0C);

    tag = "R10";
    br(5'd0, v); chk("R10 fake read returns zero", v, 0);

    tag = "R12"; src[1] = 1'b1; idle(5);
    chk("R12 edge raises irq", {31'b0, irq}, 1);
    tag = "R5"; br(5'd0, v); chk("R5 vector of src1", v, 2);
    chk("R5 irq low after ack", {31'b0, irq}, 0);
    tag = "R6"; idle(3); br(5'd0, v); chk("R6 edge cleared, held input no re-trigger", v, 0);
    src[1] = 1'b0;

    tag = "R4"; src[0] = 1'b1; idle(5);
    chk("R4 lower priority holds off irq", {31'b0, irq}, 0);
    tag = "R8"; bw(5'd1, 0); idle(2);
    chk("R8 pop lets level source in", {31'b0, irq}, 1);
    tag = "R6"; br(5'd0, v); chk("R6 level vector", v, 1);
    bw(5'd1, 0); idle(2);
    chk("R6 level source still pending", {31'b0, irq}, 1);
    src[0] = 1'b0; idle(5);

    tag = "R3"; bw(5'd5, 32'h06); idle(2);
    br(5'd0, v); chk("R3 tie goes to lower index", v, 2);
    br(5'd0, v); chk("R3 equal priority cannot preempt", v, 0);
    bw(5'd1, 0); br(5'd0, v); chk("R3 second of tie", v, 3);
    bw(5'd1, 0); idle(2);

    tag = "R9"; bw(5'd5, 32'h01); idle(2);
    chk("R9 set ignored by level source", {31'b0, irq}, 0);
    bw(5'd5, 32'h08); bw(5'd6, 32'h08); idle(2);
    chk("R9 clear drops edge pending", {31'b0, irq}, 0);

    tag = "R4"; bw(5'd3, 32'h02); bw(5'd5, 32'h02); idle(2);
    chk("R4 masked source no irq", {31'b0, irq}, 0);

    tag = "R7"; bw(5'd5, 32'h08); idle(2);
    chk("R7 low source raises irq", {31'b0, irq}, 1);
    bw(5'd2, 32'h02); idle(1);
    br(5'd0, v); chk("R7 late higher source wins", v, 2);

    tag = "R11"; dbg = 1'b1;
    br(5'd0, v); chk("R11 debug read at level 5", v, 0);
    bw(5'd1, 0); idle(2);
    br(5'd0, v); chk("R11 debug read value", v, 4);
    br(5'd0, v); chk("R11 debug read repeats", v, 4);
    chk("R11 irq kept", {31'b0, irq}, 1);
    dbg = 1'b0;
    br(5'd0, v); chk("R11 normal read after debug", v, 4);
    bw(5'd1, 0); idle(2);

    tag = "R8";
    for (int i = 0; i < N; i++) bw(5'(16 + i), 32'(8 + i));
    bw(5'd2, 32'hFF);
    for (int i = 0; i < N; i++) begin
      bw(5'd5, 32'(1 << i)); idle(2);
      br(5'd0, v); chk("R8 nested vector", v, 32'(i + 1));
    end
    bw(5'd5, 32'h01); idle(2);
    chk("R8 full nest blocks low source", {31'b0, irq}, 0);
    for (int i = 0; i < N; i++) bw(5'd1, 0);
    bw(5'd1, 0); idle(2);
    chk("R8 unwound to idle", {31'b0, irq}, 1);
    br(5'd0, v); chk("R8 vector after unwind", v, 1);
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule